// File: doc/BRIEF.md
# Memory traffic thermal throttle controller

This block watches how often the command scheduler touches each of up to four memory slots and caps the whole memory array's traffic once any one slot has been too busy. Each slot has its own activity counter. The counters restart at the start of every sampling window of programmable length. All of them are compared against a single shared threshold, which is sized for the most restrictive module.

When any slot's count goes strictly above that threshold, the block enters a throttle period. The period is a programmable number of sub-windows, and each sub-window has a programmable length. Within each sub-window, the scheduler may issue only a programmed budget of accesses. After that budget is used, the per-cycle permit signal drops for every slot. When the throttle period ends, all counters and the window timer are cleared, and monitoring starts again with a fresh window.

Firmware programs the configuration while the block is disabled and then sets the enable bit. A sticky event flag records each throttle entry until it is cleared with a write-one pulse.

Top module: `mem_thermal_throttle`

## Requirements
- R1: After reset, `issue_ok` is 1, `throttle_on` is 0 and `event_flag` is 0.
- R2: Each slot strobe in `slot_access` (bit i = slot i) increments only that slot's counter, and counters saturate at their maximum. A slot whose count is strictly greater than the shared threshold starts throttling. `throttle_on` rises in the cycle after the clock edge that registers the exceeding count, so with continuous strobes from the first enabled cycle it is seen on the (threshold+2)-th sampled cycle.
- R3: Counters restart every `cfg_win_len` cycles; a length of 0 acts as 1. At a window boundary, the strobe of that cycle becomes the first count of the new window. A slot that strobes every other cycle with a 6-cycle window and a threshold of 3 therefore never throttles.
- R4: A throttle period lasts exactly `cfg_sub_len` × `cfg_sub_count` cycles; a value of 0 acts as 1.
- R5: While throttling, every strobe issued while `issue_ok` is 1 counts against `cfg_budget`, and strobes that arrive in the same cycle count separately. `issue_ok` drops once the sub-window's issued total reaches the budget, and it rises again at the start of the next sub-window. A single `issue_ok` covers all slots.
- R6: Leaving the throttle state clears every slot counter and the window timer. Counting does not resume until the first cycle after the throttle ends, so with continuous strobes a new throttle starts after threshold+2 low cycles.
- R7: `event_flag` is set when throttling engages and stays set until an `event_clr` pulse clears it. A new engagement in the same cycle as `event_clr` wins.
- R8: When `cfg_enable` is 0, `throttle_on` is 0, `issue_ok` is 1 and all counters and timers are held cleared.
- R9: The configuration inputs are captured only while `cfg_enable` is 0. Changes made while the block is enabled have no effect until it is disabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Enables monitoring and throttling |
| cfg_win_len | input | WIN_W | Sampling window length in cycles |
| cfg_sub_len | input | SUB_W | Throttle sub-window length in cycles |
| cfg_sub_count | input | NSUB_W | Number of sub-windows in one throttle period |
| cfg_budget | input | BUD_W | Accesses permitted per sub-window while throttling |
| cfg_threshold | input | CNT_W | Shared per-slot activity threshold |
| slot_access | input | NUM_SLOTS | Per-slot access strobes from the scheduler |
| event_clr | input | 1 | Write-one pulse that clears the event flag |
| issue_ok | output | 1 | Per-cycle permit to issue memory commands |
| throttle_on | output | 1 | Throttle period in progress |
| event_flag | output | 1 | Sticky record of a throttle entry |

## Verification
The assertions assume the scheduler honours the permit. They take it that strobes arriving while `issue_ok` is low are simply not counted, rather than forbidden. They also assume configuration changes made while the block is enabled land only in the input pins, never in the captured copy. The stimulus reprograms the configuration only after dropping the enable and waiting two cycles. It changes the threshold while enabled only to show that the change is ignored. It drives strobes one half clock away from the sampling edge, so every count lands on a known edge.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic {
    ST_MON = 1'b0,
    ST_THR = 1'b1
  } thr_state_e;

  // index of the last cycle of a programmed length; a zero length acts as one
  function automatic logic [31:0] last_idx(input logic [31:0] len);
    return (len == 32'd0) ? 32'd0 : len - 32'd1;
  endfunction

  // number of set strobes in one cycle
  function automatic logic [31:0] ones(input logic [31:0] v);
    logic [31:0] acc;
    acc = 32'd0;
    for (int i = 0; i < 32; i++) acc = acc + {31'd0, v[i]};
    return acc;
  endfunction

endpackage

// File: rtl/thr_slot_counter.sv
module thr_slot_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic             inc,
  input  logic [CNT_W-1:0] threshold,
  output logic             over
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (clr)     cnt <= '0;
    else if (restart) cnt <= {{(CNT_W-1){1'b0}}, inc};
    else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
  end

  assign over = (cnt > threshold);

  // R2
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CNT_MAX && inc && !clr && !restart) |=> cnt == CNT_MAX);
  // R2
  no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !restart) |=> cnt >= $past(cnt));
  // R3
  restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !clr) |=> cnt <= 1);
endmodule

// File: rtl/thr_throttle_fsm.sv
module thr_throttle_fsm
  import thr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int SUB_W     = 8,
  parameter int NSUB_W    = 4,
  parameter int BUD_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 trigger,
  input  logic [SUB_W-1:0]     sub_len,
  input  logic [NSUB_W-1:0]    sub_num,
  input  logic [BUD_W-1:0]     budget,
  input  logic [NUM_SLOTS-1:0] slot_access,
  output logic                 throttle_on,
  output logic                 issue_ok
);
  localparam int ISS_W = BUD_W + $clog2(NUM_SLOTS + 1);

  thr_state_e        state;
  logic [SUB_W-1:0]  sub_t;
  logic [NSUB_W-1:0] sub_idx;
  logic [ISS_W-1:0]  issued;
  logic              sub_last;
  logic              per_last;
  logic              spent;
  logic [ISS_W-1:0]  step;

  assign sub_last = (32'(sub_t) == last_idx(32'(sub_len)));
  assign per_last = (32'(sub_idx) == last_idx(32'(sub_num)));
  assign spent    = (state == ST_THR) && (issued >= ISS_W'(budget));
  assign step     = ISS_W'(ones(32'(slot_access)));

  always_ff @(posedge clk) begin
    if (!rst_n || !enable) begin
      state   <= ST_MON;
      sub_t   <= '0;
      sub_idx <= '0;
      issued  <= '0;
    end else begin
      case (state)
        ST_MON: begin
          if (trigger) begin
            state   <= ST_THR;
            sub_t   <= '0;
            sub_idx <= '0;
            issued  <= '0;
          end
        end
        default: begin
          if (sub_last) begin
            sub_t  <= '0;
            issued <= '0;
            if (per_last) begin
              state   <= ST_MON;
              sub_idx <= '0;
            end else begin
              sub_idx <= sub_idx + 1'b1;
            end
          end else begin
            sub_t <= sub_t + 1'b1;
            if (!spent) issued <= issued + step;
          end
        end
      endcase
    end
  end

  assign throttle_on = enable && (state == ST_THR);
  assign issue_ok    = !enable || !spent;

  // R4
  sub_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_THR) |-> 32'(sub_idx) <= last_idx(32'(sub_num)));
  // R5
  permit_stays_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && throttle_on && !issue_ok && !sub_last) |=> (!issue_ok || !enable));
  // R5
  permit_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (throttle_on && sub_last) |=> issue_ok);
endmodule

// File: rtl/mem_thermal_throttle.sv
module mem_thermal_throttle
  import thr_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int CNT_W     = 6,
  parameter int WIN_W     = 10,
  parameter int SUB_W     = 8,
  parameter int NSUB_W    = 4,
  parameter int BUD_W     = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_enable,
  input  logic [WIN_W-1:0]     cfg_win_len,
  input  logic [SUB_W-1:0]     cfg_sub_len,
  input  logic [NSUB_W-1:0]    cfg_sub_count,
  input  logic [BUD_W-1:0]     cfg_budget,
  input  logic [CNT_W-1:0]     cfg_threshold,
  input  logic [NUM_SLOTS-1:0] slot_access,
  input  logic                 event_clr,
  output logic                 issue_ok,
  output logic                 throttle_on,
  output logic                 event_flag
);
  // captured configuration, frozen while enabled
  logic [WIN_W-1:0]  win_len_q;
  logic [SUB_W-1:0]  sub_len_q;
  logic [NSUB_W-1:0] sub_cnt_q;
  logic [BUD_W-1:0]  budget_q;
  logic [CNT_W-1:0]  thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_len_q <= '0;
      sub_len_q <= '0;
      sub_cnt_q <= '0;
      budget_q  <= '0;
      thr_q     <= '0;
    end else if (!cfg_enable) begin
      win_len_q <= cfg_win_len;
      sub_len_q <= cfg_sub_len;
      sub_cnt_q <= cfg_sub_count;
      budget_q  <= cfg_budget;
      thr_q     <= cfg_threshold;
    end
  end

  // sampling window timer
  logic [WIN_W-1:0] win_cnt;
  logic             win_last;
  logic             mon_hold;

  assign mon_hold = !cfg_enable || throttle_on;
  assign win_last = (32'(win_cnt) == last_idx(32'(win_len_q)));

  always_ff @(posedge clk) begin
    if (!rst_n || mon_hold) win_cnt <= '0;
    else if (win_last)      win_cnt <= '0;
    else                    win_cnt <= win_cnt + 1'b1;
  end

  // per-slot activity counters
  logic [NUM_SLOTS-1:0] slot_over;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    thr_slot_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (mon_hold),
      .restart   (win_last),
      .inc       (slot_access[g]),
      .threshold (thr_q),
      .over      (slot_over[g])
    );
  end

  logic trigger;
  assign trigger = cfg_enable && !throttle_on && (|slot_over);

  thr_throttle_fsm #(
    .NUM_SLOTS (NUM_SLOTS),
    .SUB_W     (SUB_W),
    .NSUB_W    (NSUB_W),
    .BUD_W     (BUD_W)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .enable      (cfg_enable),
    .trigger     (trigger),
    .sub_len     (sub_len_q),
    .sub_num     (sub_cnt_q),
    .budget      (budget_q),
    .slot_access (slot_access),
    .throttle_on (throttle_on),
    .issue_ok    (issue_ok)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         event_flag <= 1'b0;
    else if (trigger)   event_flag <= 1'b1;
    else if (event_clr) event_flag <= 1'b0;
  end

  // R2
  engage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> (throttle_on || !cfg_enable));
  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trigger |=> event_flag);
  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_flag && !event_clr) |=> event_flag);
  // R6
  rearm_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(throttle_on) && cfg_enable) |-> (win_cnt == '0 && slot_over == '0));
  // R3
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(win_cnt) <= last_idx(32'(win_len_q)));
  // R8
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!throttle_on && issue_ok));
  // R9
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && $past(cfg_enable)) |-> ($stable(thr_q) && $stable(budget_q)));
endmodule

// File: tb/sim_mem_thermal_throttle.sv
module sim_mem_thermal_throttle;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_enable = 1'b0;
  logic [9:0] cfg_win_len = '0;
  logic [7:0] cfg_sub_len = '0;
  logic [3:0] cfg_sub_count = '0;
  logic [5:0] cfg_budget = '0;
  logic [5:0] cfg_threshold = '0;
  logic [3:0] slot_access = '0;
  logic       event_clr = 1'b0;
  logic       issue_ok, throttle_on, event_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_thermal_throttle u0 (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_win_len(cfg_win_len), .cfg_sub_len(cfg_sub_len),
    .cfg_sub_count(cfg_sub_count), .cfg_budget(cfg_budget),
    .cfg_threshold(cfg_threshold), .slot_access(slot_access),
    .event_clr(event_clr), .issue_ok(issue_ok),
    .throttle_on(throttle_on), .event_flag(event_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setup(input int z, input int y, input int n, input int bud, input int thr);
    @(negedge clk);
    cfg_enable = 1'b0;
    slot_access = '0;
    cfg_win_len = 10'(z);
    cfg_sub_len = 8'(y);
    cfg_sub_count = 4'(n);
    cfg_budget = 6'(bud);
    cfg_threshold = 6'(thr);
    @(negedge clk);
    @(negedge clk);
    cfg_enable = 1'b1;
  endtask

  // counts sampled cycles until throttle_on is seen high (inclusive)
  task automatic cycles_to_throttle(output int n, input int limit);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      n++;
      if (throttle_on) break;
    end
    if (!throttle_on) n = -1;
  endtask

  task automatic t_reset;
    chk("R1 issue_ok", int'(issue_ok), 1);
    chk("R1 throttle_on", int'(throttle_on), 0);
    chk("R1 event_flag", int'(event_flag), 0);
  endtask

  task automatic t_cross_period_budget(input logic [3:0] pat, input int bud, input int exp_ok);
    int n, hi, ok;
    setup(200, 5, 3, bud, 3);
    slot_access = pat;
    cycles_to_throttle(n, 50);
    chk("R2 cycles to throttle", n, 5);
    chk("R7 flag set on entry", int'(event_flag), 1);
    hi = 0; ok = 0;
    while (throttle_on && hi < 100) begin
      hi++;
      if (issue_ok) ok++;
      @(negedge clk);
    end
    chk("R4 throttle length", hi, 15);
    chk("R5 permitted cycles while throttled", ok, exp_ok);
    chk("R5 permit after throttle", int'(issue_ok), 1);
    n = 1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (throttle_on) break;
      n++;
    end
    chk("R6 low cycles before re-throttle", n, 5);
    slot_access = '0;
  endtask

  task automatic t_window(input int z, input int exp_hit);
    int hit;
    setup(z, 4, 1, 1, 3);
    hit = 0;
    for (int i = 0; i < 60; i++) begin
      slot_access = (i % 2 == 0) ? 4'b0001 : 4'b0000;
      @(negedge clk);
      if (throttle_on) hit = 1;
    end
    slot_access = '0;
    chk($sformatf("R3 window %0d throttled", z), hit, exp_hit);
  endtask

  task automatic t_slots;
    int hit, n;
    setup(300, 4, 1, 1, 3);
    hit = 0;
    slot_access = 4'b1111;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (throttle_on) hit = 1; end
    slot_access = 4'b0000;
    for (int i = 0; i < 3; i++) begin @(negedge clk); if (throttle_on) hit = 1; end
    chk("R2 separate counts stay under", hit, 0);
    slot_access = 4'b1000;
    @(negedge clk);
    slot_access = 4'b0000;
    cycles_to_throttle(n, 10);
    chk("R2 fourth access on one slot", n, 1);
    chk("R5 single permit for all slots", int'(issue_ok), 1);
  endtask

  task automatic t_flag;
    int n;
    setup(300, 2, 1, 1, 3);
    slot_access = 4'b0010;
    cycles_to_throttle(n, 20);
    slot_access = '0;
    repeat (4) @(negedge clk);
    chk("R7 flag sticky after throttle", int'(event_flag), 1);
    event_clr = 1'b1;
    @(negedge clk);
    event_clr = 1'b0;
    chk("R7 flag cleared", int'(event_flag), 0);
  endtask

  task automatic t_disable;
    int n;
    setup(300, 20, 4, 0, 3);
    slot_access = 4'b0100;
    cycles_to_throttle(n, 20);
    chk("R5 zero budget blocks", int'(issue_ok), 0);
    @(negedge clk);
    cfg_enable = 1'b0;
    @(negedge clk);
    chk("R8 throttle dropped", int'(throttle_on), 0);
    chk("R8 permit high", int'(issue_ok), 1);
    repeat (3) @(negedge clk);
    cfg_enable = 1'b1;
    cycles_to_throttle(n, 20);
    chk("R8 counters restarted", n, 5);
    slot_access = '0;
  endtask

  task automatic t_cfg_freeze;
    int n;
    setup(300, 2, 1, 1, 3);
    @(negedge clk);
    cfg_threshold = 6'd30;
    slot_access = 4'b0001;
    cycles_to_throttle(n, 50);
    chk("R9 change while enabled ignored", n, 5);
    setup(300, 2, 1, 1, 5);
    slot_access = 4'b0001;
    cycles_to_throttle(n, 50);
    chk("R9 change while disabled applied", n, 7);
    slot_access = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cross_period_budget(4'b0001, 2, 6);
    t_cross_period_budget(4'b0011, 4, 6);
    t_window(6, 0);
    t_window(40, 1);
    t_slots();
    t_flag();
    t_disable();
    t_cfg_freeze();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule